// File: doc/BRIEF.md
# Cascaded Microsecond Timebase with Two-Stage Deadline Compare

This block keeps a free-running 32-bit time value in microseconds. It builds the value from two linked 16-bit counters. A programmable prescaler divides the system clock so that the lower counter advances once per microsecond. The upper counter advances once each time the lower counter rolls over from its all-ones value to zero. Software loads or reads the whole 32-bit value through a small register port. A read returns both halves captured on the same clock edge.

Software programs a 32-bit deadline. The block compares it in two stages. If the deadline lies in a later upper-half epoch, only the upper compare is armed. When the upper compare hits, the block arms the lower compare on the same cycle, and it fires at once if the lower half already matches. If the deadline lies in the current epoch, only the lower compare is armed. A deadline that has already passed arms nothing. One interrupt line reports that the deadline was reached, or that the upper counter wrapped (when that source is enabled). A two-bit cause output tells the two sources apart.

Register map: address 0 is the count, address 1 the deadline, address 2 the status, address 3 the control, address 4 the prescaler reload, and address 5 the force-update command. Status bits: bit 0 is upper-counter wrap, bit 1 is upper-stage match, bit 2 is deadline reached. Control bits: bit 0 is run, bit 1 is wrap-interrupt enable. Reads have one cycle of latency.

Top module: `usec_timebase`

## Requirements
- R1: After reset the count, status and control read 0 and `irq` is low. A write to address 0 loads bits 31:16 into the upper counter and bits 15:0 into the lower counter. A read of address 0 returns both halves as they stood on the clock edge that sampled `rdEn`, with `rdData` valid after that edge.
- R2: While run (control bit 0) is set, the lower counter steps by one on every prescaler tick. The upper counter steps by one only on a tick where the lower counter rolls from 0xFFFF to 0, so the 32-bit value carries without tearing.
- R3: With active prescaler reload P, a tick occurs every P+1 clock cycles. A write to address 5 copies the pending reload into the active prescaler at once and restarts the prescaler phase. A count write also restarts the phase.
- R4: A write to address 4 only sets the pending reload. It becomes active on the next lower-counter rollover, and the tick rate is unchanged until then.
- R5: An upper-counter rollover from 0xFFFF to 0 sets status bit 0 whatever the enable. `irq` reflects it only while control bit 1 is set, and `irqCause` bit 1 then reads 1.
- R6: When the deadline's upper half equals the current upper count and its lower half is greater than the current lower count, the lower compare alone is armed. Status bit 2 sets, `irq` rises and `irqCause` bit 0 reads 1 on the edge that sees the count equal to the deadline. Address 1 reads back the last deadline.
- R7: When the deadline's upper half exceeds the current upper count, the upper compare alone is armed. Its hit sets status bit 1 and arms the lower compare. The deadline flag then sets on the edge that sees the full deadline.
- R8: If the upper compare hits while the lower half already equals the deadline's lower half, the deadline flag sets on that same edge.
- R9: Every deadline write clears status bits 1 and 2. A deadline at or before the current count arms no compare and raises no interrupt.
- R10: Status bits clear only where a 1 is written to address 2. Writing 1 to another bit leaves them unchanged.
- R11: A count write disarms both compares, so a deadline pending at that time never fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 32 | Register write data |
| rdEn | input | 1 | Register read strobe |
| rdAddr | input | 3 | Register read address |
| rdData | output | 32 | Read data, valid the cycle after `rdEn` |
| irq | output | 1 | Interrupt request |
| irqCause | output | 2 | Bit 0 deadline reached, bit 1 enabled upper wrap |

## Verification
The counting function is exercised at prescaler reloads of 0, 1 and 3. Back-to-back reads across a lower rollover separate a correct carry from a torn or late one. A pending reload that is written without a force is observed across a rollover, which separates deferred loading from immediate loading. Deadlines are tried in four forms: same epoch, later epoch with a nonzero lower half, later epoch with a zero lower half, and already past. The exact cycle on which `irq` rises is sampled, so an off-by-one compare, a missed second stage or a spurious past-deadline interrupt each show up differently. Wrap-flag gating, selective write-one-to-clear and cancellation by a count write round out the patterns.

// File: rtl/utb_pkg.sv
package utb_pkg;

  typedef enum logic [2:0] {
    REG_COUNT    = 3'd0,
    REG_DEADLINE = 3'd1,
    REG_STATUS   = 3'd2,
    REG_CONTROL  = 3'd3,
    REG_PRESCALE = 3'd4,
    REG_FORCE    = 3'd5
  } regSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadCnt;
    logic setPre;
    logic forceUpd;
    logic armHi;
    logic armLo;
    logic disarm;
  } dpStrobe_t;

  // Events from datapath to control
  typedef struct packed {
    logic hiWrap;
    logic hiHit;
    logic loFire;
  } dpEvent_t;

endpackage

// File: rtl/utb_datapath.sv
module utb_datapath
  import utb_pkg::*;
#(
  parameter int unsigned HALF_W    = 16,
  parameter int unsigned PRE_W     = 8,
  parameter int unsigned PRE_RESET = 0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  run,
  input  dpStrobe_t             strb,
  input  logic [2*HALF_W-1:0]   wrData,
  output logic [HALF_W-1:0]     hiCnt,
  output logic [HALF_W-1:0]     loCnt,
  output logic [PRE_W-1:0]      preLoad,
  output dpEvent_t              evt
);

  localparam int unsigned DW = 2 * HALF_W;
  localparam logic [HALF_W-1:0] HALF_MAX = '1;

  logic [PRE_W-1:0]  preActive;
  logic [PRE_W-1:0]  preCnt;
  logic [HALF_W-1:0] hiCmp;
  logic [HALF_W-1:0] loCmp;
  logic              hiCmpEn;
  logic              loCmpEn;
  logic              tick;
  logic              loWrap;
  logic              hiHit;
  logic              loFire;

  always_comb begin
    tick   = run && (preCnt == preActive);
    loWrap = tick && (loCnt == HALF_MAX);
    hiHit  = hiCmpEn && (hiCnt == hiCmp);
    // second stage checked in the same cycle as the upper hit
    loFire = (loCmpEn || hiHit) && (loCnt == loCmp);
  end

  assign evt.hiWrap = loWrap && (hiCnt == HALF_MAX);
  assign evt.hiHit  = hiHit;
  assign evt.loFire = loFire;

  // Prescaler: pending and active reload, phase counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      preLoad   <= PRE_W'(PRE_RESET);
      preActive <= PRE_W'(PRE_RESET);
      preCnt    <= '0;
    end else begin
      if (strb.setPre) preLoad <= wrData[PRE_W-1:0];
      if (strb.forceUpd) begin
        preActive <= preLoad;
        preCnt    <= '0;
      end else if (strb.loadCnt) begin
        preCnt <= '0;
      end else if (tick) begin
        preCnt <= '0;
        if (loWrap) preActive <= preLoad;
      end else if (run) begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  // Chained counters
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiCnt <= '0;
      loCnt <= '0;
    end else if (strb.loadCnt) begin
      hiCnt <= wrData[DW-1:HALF_W];
      loCnt <= wrData[HALF_W-1:0];
    end else if (tick) begin
      loCnt <= loCnt + 1'b1;
      if (loWrap) hiCnt <= hiCnt + 1'b1;
    end
  end

  // Compare registers and enables
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiCmp   <= '0;
      loCmp   <= '0;
      hiCmpEn <= 1'b0;
      loCmpEn <= 1'b0;
    end else if (strb.loadCnt || strb.disarm) begin
      hiCmpEn <= 1'b0;
      loCmpEn <= 1'b0;
    end else if (strb.armHi || strb.armLo) begin
      hiCmp   <= wrData[DW-1:HALF_W];
      loCmp   <= wrData[HALF_W-1:0];
      hiCmpEn <= strb.armHi;
      loCmpEn <= strb.armLo;
    end else if (hiHit) begin
      hiCmpEn <= 1'b0;
      loCmpEn <= !loFire;
    end else if (loFire) begin
      loCmpEn <= 1'b0;
    end
  end

  a_r2_hi_moves_on_carry: assert property (@(posedge clk) disable iff (!rstN)
    (hiCnt != $past(hiCnt)) |->
      ($past(strb.loadCnt) || ($past(loCnt) == HALF_MAX && loCnt == '0)));

  a_r4_prescale_on_update: assert property (@(posedge clk) disable iff (!rstN)
    (preActive != $past(preActive)) |->
      ($past(strb.forceUpd) || ($past(loCnt) == HALF_MAX && loCnt == '0)));

  a_r11_load_cancels: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadCnt |=> (!evt.loFire && !evt.hiHit));

endmodule

// File: rtl/utb_control.sv
module utb_control
  import utb_pkg::*;
#(
  parameter int unsigned HALF_W = 16,
  parameter int unsigned PRE_W  = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [2:0]            wrAddr,
  input  logic [2*HALF_W-1:0]   wrData,
  input  logic                  rdEn,
  input  logic [2:0]            rdAddr,
  output logic [2*HALF_W-1:0]   rdData,
  input  logic [HALF_W-1:0]     hiCnt,
  input  logic [HALF_W-1:0]     loCnt,
  input  logic [PRE_W-1:0]      preLoad,
  input  dpEvent_t              evt,
  output dpStrobe_t             strb,
  output logic                  run,
  output logic                  irq,
  output logic [1:0]            irqCause
);

  localparam int unsigned DW = 2 * HALF_W;
  localparam logic [HALF_W-1:0] HALF_MAX = '1;

  logic          wrapIe;
  logic          wrapFlag;
  logic          hiFlag;
  logic          dlFlag;
  logic [DW-1:0] lastDeadline;
  logic          wrDeadline;
  logic          wrStatus;
  logic          wrControl;
  logic [HALF_W-1:0] dlHi;
  logic [HALF_W-1:0] dlLo;

  always_comb begin
    dlHi       = wrData[DW-1:HALF_W];
    dlLo       = wrData[HALF_W-1:0];
    wrDeadline = wrEn && (wrAddr == REG_DEADLINE);
    wrStatus   = wrEn && (wrAddr == REG_STATUS);
    wrControl  = wrEn && (wrAddr == REG_CONTROL);
    strb.loadCnt  = wrEn && (wrAddr == REG_COUNT);
    strb.setPre   = wrEn && (wrAddr == REG_PRESCALE);
    strb.forceUpd = wrEn && (wrAddr == REG_FORCE);
    strb.armHi    = wrDeadline && (dlHi > hiCnt);
    strb.armLo    = wrDeadline && (dlHi == hiCnt) && (dlLo > loCnt);
    strb.disarm   = wrDeadline && !strb.armHi && !strb.armLo;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrapFlag     <= 1'b0;
      hiFlag       <= 1'b0;
      dlFlag       <= 1'b0;
      run          <= 1'b0;
      wrapIe       <= 1'b0;
      lastDeadline <= '0;
    end else begin
      wrapFlag <= evt.hiWrap || (wrapFlag && !(wrStatus && wrData[0]));
      if (wrDeadline) begin
        hiFlag       <= 1'b0;
        dlFlag       <= 1'b0;
        lastDeadline <= wrData;
      end else begin
        hiFlag <= evt.hiHit  || (hiFlag && !(wrStatus && wrData[1]));
        dlFlag <= evt.loFire || (dlFlag && !(wrStatus && wrData[2]));
      end
      if (wrControl) begin
        run    <= wrData[0];
        wrapIe <= wrData[1];
      end
    end
  end

  // Read port: count halves sampled on one edge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (rdEn) begin
      case (regSel_e'(rdAddr))
        REG_COUNT:    rdData <= {hiCnt, loCnt};
        REG_DEADLINE: rdData <= lastDeadline;
        REG_STATUS:   rdData <= {{(DW-3){1'b0}}, dlFlag, hiFlag, wrapFlag};
        REG_CONTROL:  rdData <= {{(DW-2){1'b0}}, wrapIe, run};
        REG_PRESCALE: rdData <= {{(DW-PRE_W){1'b0}}, preLoad};
        default:      rdData <= '0;
      endcase
    end
  end

  always_comb begin
    irqCause = {wrapFlag && wrapIe, dlFlag};
    irq      = |irqCause;
  end

  a_r6_fire_at_deadline: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dlFlag) |-> ($past({hiCnt, loCnt}) == lastDeadline));

  a_r9_deadline_write_clears: assert property (@(posedge clk) disable iff (!rstN)
    wrDeadline |=> (!dlFlag && !hiFlag));

  a_r5_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    ($past(hiCnt) == HALF_MAX && $past(loCnt) == HALF_MAX && hiCnt == '0 &&
     loCnt == '0 && !$past(strb.loadCnt)) |-> wrapFlag);

  a_r10_w1c_clears: assert property (@(posedge clk) disable iff (!rstN)
    (wrStatus && wrData[2] && !evt.loFire) |=> !dlFlag);

endmodule

// File: rtl/usec_timebase.sv
module usec_timebase
  import utb_pkg::*;
#(
  parameter int unsigned HALF_W    = 16,
  parameter int unsigned PRE_W     = 8,
  parameter int unsigned PRE_RESET = 0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [2:0]          wrAddr,
  input  logic [2*HALF_W-1:0] wrData,
  input  logic                rdEn,
  input  logic [2:0]          rdAddr,
  output logic [2*HALF_W-1:0] rdData,
  output logic                irq,
  output logic [1:0]          irqCause
);

  dpStrobe_t         strb;
  dpEvent_t          evt;
  logic              run;
  logic [HALF_W-1:0] hiCnt;
  logic [HALF_W-1:0] loCnt;
  logic [PRE_W-1:0]  preLoad;

  utb_control #(.HALF_W(HALF_W), .PRE_W(PRE_W)) i_control (
    .clk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
    .hiCnt(hiCnt), .loCnt(loCnt), .preLoad(preLoad), .evt(evt),
    .strb(strb), .run(run), .irq(irq), .irqCause(irqCause)
  );

  utb_datapath #(.HALF_W(HALF_W), .PRE_W(PRE_W), .PRE_RESET(PRE_RESET)) i_datapath (
    .clk(clk), .rstN(rstN), .run(run), .strb(strb), .wrData(wrData),
    .hiCnt(hiCnt), .loCnt(loCnt), .preLoad(preLoad), .evt(evt)
  );

endmodule

// File: tb/test_usec_timebase.sv
module test_usec_timebase;

  localparam logic [2:0] A_COUNT = 3'd0, A_DL = 3'd1, A_STAT = 3'd2,
                         A_CTRL = 3'd3, A_PRE = 3'd4, A_FORCE = 3'd5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [2:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        irq;
  logic [1:0]  irqCause;

  int nChecks = 0;
  int nFails  = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];
  logic        rdSeen = 1'b0;

  always #2 clk = ~clk;

  usec_timebase i_usec_timebase (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .irq(irq), .irqCause(irqCause)
  );

  always @(posedge clk) rdSeen <= rdEn;

  // Monitor: pops expected read data and compares
  always @(negedge clk) begin
    if (rdSeen && expQ.size() > 0) begin
      logic [31:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      nChecks++;
      if (rdData !== e) begin
        nFails++;
        $display("FAIL %s read: actual %h expected %h", t, rdData, e);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string t);
    expQ.push_back(e);
    tagQ.push_back(t);
    rdEn = 1'b1; rdAddr = a;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] e);
    nChecks++;
    if (act !== e) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", t, act, e);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired, every requirement unfinished");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state and load/read
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    rd(A_COUNT, 32'd0, "R1 reset count");
    rd(A_STAT, 32'd0, "R1 reset status");
    rd(A_CTRL, 32'd0, "R1 reset control");
    wr(A_COUNT, 32'h1234_5678);
    idle(3);
    rd(A_COUNT, 32'h1234_5678, "R1 load stopped");

    // R2 carry across lower rollover, prescale 0
    wr(A_CTRL, 32'd1);
    wr(A_COUNT, 32'h0000_FFFE);
    rd(A_COUNT, 32'h0000_FFFE, "R2 count t0");
    rd(A_COUNT, 32'h0000_FFFF, "R2 count t1");
    rd(A_COUNT, 32'h0001_0000, "R2 carry");

    // R4 pending reload deferred to rollover
    wr(A_CTRL, 32'd0);
    wr(A_PRE, 32'd3);
    wr(A_COUNT, 32'h0000_0010);
    wr(A_CTRL, 32'd1);
    rd(A_COUNT, 32'h0000_0010, "R4 old rate a");
    rd(A_COUNT, 32'h0000_0011, "R4 old rate b");
    wr(A_COUNT, 32'h0000_FFFF);
    rd(A_COUNT, 32'h0000_FFFF, "R4 before wrap");
    rd(A_COUNT, 32'h0001_0000, "R4 at wrap");
    idle(2);
    rd(A_COUNT, 32'h0001_0000, "R4 new rate hold");
    rd(A_COUNT, 32'h0001_0001, "R4 new rate step");
    rd(A_PRE, 32'd3, "R4 pending readback");

    // R3 force update, reload 1
    wr(A_CTRL, 32'd0);
    wr(A_PRE, 32'd1);
    wr(A_FORCE, 32'd0);
    wr(A_COUNT, 32'h0030_0000);
    wr(A_CTRL, 32'd1);
    rd(A_COUNT, 32'h0030_0000, "R3 phase 0");
    rd(A_COUNT, 32'h0030_0000, "R3 phase 1");
    rd(A_COUNT, 32'h0030_0001, "R3 step");

    // R5 upper wrap flag and enable gating
    wr(A_CTRL, 32'd0);
    wr(A_PRE, 32'd0);
    wr(A_FORCE, 32'd0);
    wr(A_COUNT, 32'hFFFF_FFFF);
    wr(A_CTRL, 32'd1);
    idle(1);
    chk("R5 irq masked", {31'd0, irq}, 32'd0);
    rd(A_STAT, 32'd1, "R5 wrap flag");
    wr(A_CTRL, 32'd3);
    chk("R5 irq enabled", {31'd0, irq}, 32'd1);
    chk("R5 cause", {30'd0, irqCause}, 32'd2);
    wr(A_STAT, 32'd1);
    chk("R10 wrap cleared", {31'd0, irq}, 32'd0);

    // R6 same-epoch deadline
    wr(A_CTRL, 32'd0);
    wr(A_COUNT, 32'h0002_0100);
    wr(A_DL, 32'h0002_0105);
    wr(A_CTRL, 32'd1);
    idle(5);
    chk("R6 not yet", {31'd0, irq}, 32'd0);
    idle(1);
    chk("R6 irq at deadline", {31'd0, irq}, 32'd1);
    chk("R6 cause", {30'd0, irqCause}, 32'd1);
    rd(A_STAT, 32'd4, "R6 status");
    rd(A_DL, 32'h0002_0105, "R6 deadline readback");

    // R7 later epoch, two stages
    wr(A_CTRL, 32'd0);
    wr(A_COUNT, 32'h0003_FFFA);
    wr(A_DL, 32'h0004_0002);
    chk("R9 new deadline clears", {31'd0, irq}, 32'd0);
    wr(A_CTRL, 32'd1);
    idle(8);
    chk("R7 not yet", {31'd0, irq}, 32'd0);
    idle(1);
    chk("R7 irq at deadline", {31'd0, irq}, 32'd1);
    rd(A_STAT, 32'd6, "R7 status");

    // R8 lower half zero, same-cycle chain
    wr(A_CTRL, 32'd0);
    wr(A_COUNT, 32'h0005_FFFE);
    wr(A_DL, 32'h0006_0000);
    wr(A_CTRL, 32'd1);
    idle(2);
    chk("R8 not yet", {31'd0, irq}, 32'd0);
    idle(1);
    chk("R8 irq same cycle", {31'd0, irq}, 32'd1);
    rd(A_STAT, 32'd6, "R8 status");

    // R9 past deadlines
    wr(A_CTRL, 32'd0);
    wr(A_COUNT, 32'h0007_0050);
    wr(A_DL, 32'h0007_0040);
    rd(A_STAT, 32'd0, "R9 flags cleared");
    wr(A_CTRL, 32'd1);
    idle(100);
    chk("R9 past low", {31'd0, irq}, 32'd0);
    wr(A_DL, 32'h0006_FFFF);
    idle(100);
    chk("R9 past high", {31'd0, irq}, 32'd0);
    rd(A_STAT, 32'd0, "R9 status");

    // R11 count write cancels
    wr(A_CTRL, 32'd0);
    wr(A_COUNT, 32'h0008_0000);
    wr(A_DL, 32'h0008_0010);
    wr(A_COUNT, 32'h0008_0000);
    wr(A_CTRL, 32'd1);
    idle(40);
    chk("R11 no irq", {31'd0, irq}, 32'd0);
    rd(A_STAT, 32'd0, "R11 status");

    // R10 selective write-one-to-clear
    wr(A_CTRL, 32'd0);
    wr(A_COUNT, 32'h0009_0000);
    wr(A_DL, 32'h0009_0003);
    wr(A_CTRL, 32'd1);
    idle(5);
    chk("R10 armed fire", {31'd0, irq}, 32'd1);
    wr(A_STAT, 32'd2);
    chk("R10 other bit kept", {31'd0, irq}, 32'd1);
    wr(A_STAT, 32'd4);
    chk("R10 cleared", {31'd0, irq}, 32'd0);
    rd(A_STAT, 32'd0, "R10 status");

    idle(2);
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule